// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle processor and picks the address that the counter takes at the next clock edge. Each cycle it forms the sequential address, one four-byte instruction word past the current one. In parallel it forms a relative branch address. The branch address is the sequential address plus a 16-bit signed word displacement that has been scaled to bytes.

Decode logic drives two strobes, one for branch-if-equal and one for branch-if-not-equal. The execute stage supplies the zero flag, which it derives by subtracting the two compared register operands. When a strobe is set and its condition holds, the relative address is loaded. In every other case the sequential address is loaded. The current counter and the intermediate addresses are all visible as outputs, so neighbouring logic can use them.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0 after that edge. The reset is synchronous.
- R2: When neither `br_eq_i` nor `br_ne_i` is high, `pc_o` advances by 4 at each edge, whatever the value of `alu_zero_i`.
- R3: With `br_eq_i` high and `alu_zero_i` equal to 1, `pc_o` loads `(pc_o + 4) + (sign-extended offset_i << 2)` at the next edge.
- R4: With `br_eq_i` high and `alu_zero_i` equal to 0, the branch is not taken, and `pc_o` advances by 4.
- R5: With `br_ne_i` high, the branch is taken when `alu_zero_i` is 0 and not taken when it is 1.
- R6: `offset_i` is read as two's complement, so a negative value gives a target below `pc_o + 4`. An offset of 0xFFFF (-1) gives a target equal to `pc_o`, and the target wraps modulo 2^32.
- R7: The two low bits of `pc_o` are always 00.
- R8: In the same cycle, `pc_seq_o` equals `pc_o + 4` and `target_o` equals the R3 address. `taken_o` is 1 exactly when R3 or R5 calls for a taken branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| br_eq_i | input | 1 | Decoded branch-if-equal strobe |
| br_ne_i | input | 1 | Decoded branch-if-not-equal strobe |
| alu_zero_i | input | 1 | Zero flag from the operand subtraction |
| offset_i | input | 16 | Signed word displacement from the instruction |
| pc_o | output | 32 | Current program counter |
| pc_seq_o | output | 32 | Sequential address, pc_o + 4 |
| target_o | output | 32 | Relative branch address |
| taken_o | output | 1 | Branch decision for this cycle |

## Verification
The bench drives an offset of -1, which should send the counter back to the current instruction. A design that zero-extends the offset or adds it to the unincremented counter lands elsewhere. A displacement of -16 from a low address must wrap below zero, and the largest positive displacement must be scaled by four. Either mistake shows up when the scaling is omitted or the extension is wrong. The bench also swaps the sense of the zero flag for each branch kind and toggles the zero flag with no strobe set, which exposes an inverted condition or a decision that ignores the strobes. A reset in mid-run checks that the counter returns to zero from an arbitrary address.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
    parameter int unsigned PC_W     = 32;
    parameter int unsigned OFS_W    = 16;
    parameter int unsigned WORD_B   = 4;
    localparam int unsigned ALIGN_W = $clog2(WORD_B);

    typedef logic [PC_W-1:0]  pc_t;
    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        SEL_SEQ    = 1'b0,
        SEL_BRANCH = 1'b1
    } pc_sel_e;

    typedef struct packed {
        pc_t pc;
    } pc_state_t;
endpackage

// File: rtl/nextpc_seq_add.sv
module nextpc_seq_add #(
    parameter int unsigned W    = 32,
    parameter int unsigned STEP = 4
) (
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] seq_o
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_comb begin
        seq_o = pc_i + STEP_V;
    end
endmodule

// File: rtl/nextpc_target_gen.sv
module nextpc_target_gen #(
    parameter int unsigned W     = 32,
    parameter int unsigned OFS_W = 16,
    parameter int unsigned SHIFT = 2
) (
    input  logic [W-1:0]     seq_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [W-1:0]     target_o
);
    localparam int unsigned EXT_W = W - OFS_W;

    logic [W-1:0] ofs_ext;
    logic [W-1:0] ofs_bytes;

    generate
        if (EXT_W > 0) begin : g_ext
            always_comb ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
        end else begin : g_noext
            always_comb ofs_ext = ofs_i[W-1:0];
        end
    endgenerate

    always_comb begin
        ofs_bytes = ofs_ext << SHIFT;
        target_o  = seq_i + ofs_bytes;
    end
endmodule

// File: rtl/nextpc_decide.sv
module nextpc_decide
    import nextpc_pkg::*;
(
    input  logic    br_eq_i,
    input  logic    br_ne_i,
    input  logic    zero_i,
    output pc_sel_e sel_o
);
    logic eq_hit;
    logic ne_hit;

    always_comb begin
        eq_hit = br_eq_i & zero_i;
        ne_hit = br_ne_i & ~zero_i;
        sel_o  = (eq_hit | ne_hit) ? SEL_BRANCH : SEL_SEQ;
    end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        br_eq_i,
    input  logic        br_ne_i,
    input  logic        alu_zero_i,
    input  logic [15:0] offset_i,
    output logic [31:0] pc_o,
    output logic [31:0] pc_seq_o,
    output logic [31:0] target_o,
    output logic        taken_o
);
    pc_state_t state_d, state_q;
    pc_t       seq_w, tgt_w;
    pc_sel_e   sel_w;

    nextpc_seq_add #(.W(PC_W), .STEP(WORD_B)) u_seq (
        .pc_i  (state_q.pc),
        .seq_o (seq_w)
    );

    nextpc_target_gen #(.W(PC_W), .OFS_W(OFS_W), .SHIFT(ALIGN_W)) u_tgt (
        .seq_i    (seq_w),
        .ofs_i    (offset_i),
        .target_o (tgt_w)
    );

    nextpc_decide u_dec (
        .br_eq_i (br_eq_i),
        .br_ne_i (br_ne_i),
        .zero_i  (alu_zero_i),
        .sel_o   (sel_w)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.pc = RESET_PC;
        end else if (sel_w == SEL_BRANCH) begin
            state_d.pc = tgt_w;
        end else begin
            state_d.pc = seq_w;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pc_o     = state_q.pc;
    assign pc_seq_o = seq_w;
    assign target_o = tgt_w;
    assign taken_o  = (sel_w == SEL_BRANCH);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    a_r1_reset_zero: assert property (@(posedge clk) rst_q |-> pc_o == RESET_PC);
    a_r2_no_strobe_seq: assert property (@(posedge clk) disable iff (rst)
        (!br_eq_i && !br_ne_i) |=> pc_o == $past(pc_seq_o));
    a_r3_taken_loads_target: assert property (@(posedge clk) disable iff (rst)
        taken_o |=> pc_o == $past(target_o));
    a_r4_eq_clear_not_taken: assert property (@(posedge clk) disable iff (rst)
        (br_eq_i && !br_ne_i && !alu_zero_i) |-> !taken_o);
    a_r5_ne_set_not_taken: assert property (@(posedge clk) disable iff (rst)
        (br_ne_i && !br_eq_i && alu_zero_i) |-> !taken_o);
    a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
        rst_q == 1'b0 |-> pc_o[1:0] == 2'b00);
    a_r8_seq_ahead: assert property (@(posedge clk) disable iff (rst)
        pc_seq_o - pc_o == 32'd4);
endmodule

// File: tb/tb_nextpc_unit.sv
module tb_nextpc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        br_eq_i = 1'b0;
    logic        br_ne_i = 1'b0;
    logic        alu_zero_i = 1'b0;
    logic [15:0] offset_i = 16'h0;
    logic [31:0] pc_o, pc_seq_o, target_o;
    logic        taken_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_pc = 32'h0;

    typedef struct {
        logic [31:0] pc;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nextpc_unit dut (
        .clk(clk), .rst(rst), .br_eq_i(br_eq_i), .br_ne_i(br_ne_i),
        .alu_zero_i(alu_zero_i), .offset_i(offset_i), .pc_o(pc_o),
        .pc_seq_o(pc_seq_o), .target_o(target_o), .taken_o(taken_o)
    );

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(bit r, bit eq, bit ne, bit z, logic [15:0] off, string tag);
        logic [31:0] seq, tgt, nxt;
        bit tk;
        @(negedge clk);
        rst = r; br_eq_i = eq; br_ne_i = ne; alu_zero_i = z; offset_i = off;
        #1;
        seq = model_pc + 32'd4;
        tgt = seq + ({{16{off[15]}}, off} << 2);
        tk  = (eq && z) || (ne && !z);
        if (!r) begin
            check32({"R8 seq ", tag}, pc_seq_o, seq);
            check32({"R8 target ", tag}, target_o, tgt);
            check32({"R8 taken ", tag}, {31'b0, taken_o}, {31'b0, tk});
        end
        nxt = r ? 32'h0 : (tk ? tgt : seq);
        sb_q.push_back('{nxt, tag});
        model_pc = nxt;
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check32(it.tag, pc_o, it.pc);
                check32({"R7 align ", it.tag}, {30'b0, pc_o[1:0]}, 32'h0);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : driver
        drive(1, 0, 0, 0, 16'h0,    "R1 reset a");
        drive(1, 1, 0, 1, 16'h3,    "R1 reset b");
        drive(0, 0, 0, 0, 16'h3,    "R2 seq z0");
        drive(0, 0, 0, 1, 16'h3,    "R2 seq z1");
        drive(0, 0, 0, 1, 16'hFFFF, "R2 seq neg");
        drive(0, 1, 0, 1, 16'h3,    "R3 beq +3");
        drive(0, 1, 0, 0, 16'h3,    "R4 beq clear");
        drive(0, 0, 1, 0, 16'h0,    "R5 bne 0");
        drive(0, 0, 1, 1, 16'h3,    "R5 bne set");
        drive(0, 1, 0, 1, 16'h0,    "R3 beq 0");
        drive(0, 1, 0, 1, 16'hFFFF, "R6 beq -1");
        drive(0, 0, 1, 0, 16'hFFF0, "R6 bne wrap");
        drive(0, 1, 0, 1, 16'h7FFF, "R3 beq max");
        drive(0, 0, 1, 0, 16'h8000, "R6 bne min");
        drive(1, 0, 1, 0, 16'h3,    "R1 reset mid");
        drive(0, 0, 0, 0, 16'h0,    "R2 after reset");
        drive(0, 0, 1, 0, 16'h3,    "R5 bne +3");
        @(negedge clk);
        br_eq_i = 0; br_ne_i = 0;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule